// File: doc/BRIEF.md
# Prescaled BCD Calendar Timekeeper

The block keeps time of day and a calendar date, both held in packed BCD. A low-rate RTC clock, presented to the block as a single-cycle enable `rtcEn` in the system clock domain, feeds two down-counting dividers in cascade. The first is a short asynchronous-style stage and the second is a longer synchronous stage. Each time both stages wrap together, the calendar advances by one second. The calendar carries seconds into minutes, hours, day of month, month and a two-digit year that spans 2000 to 2099. A weekday counter advances with every new day.

Software never reads the live calendar. It reads a pair of shadow words, time and date. Both words are refreshed together on every RTC edge. A valid flag tells software when the shadows are coherent. Software clears the flag, and hardware raises it again on the second RTC edge after the clear. Time, date and divider values can be loaded only while init mode is held. While init mode is held, the calendar is frozen. When init mode ends, both dividers restart from their reload values.

Top module: `bcd_calendar`

## Requirements
- R1: The time word packs BCD seconds in bits [6:0], minutes in [14:8] and hours (24-hour) in [21:16]. All other bits read zero.
- R2: The date word packs BCD day of month in [5:0], month in [12:8], weekday (binary) in [15:13] and two-digit BCD year in [23:16]. All other bits read zero.
- R3: A divider load takes the async reload from `wrData[22:16]` and the sync reload from `wrData[14:0]`. The calendar advances once every (async+1)*(sync+1) RTC edges. After reset the reload values are 127 and 255.
- R4: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the date.
- R5: The day of month wraps to 1 after the last day of the month. Months 4, 6, 9 and 11 have 30 days. Month 2 has 29 days when the year is divisible by 4 and 28 days otherwise. All other months have 31 days.
- R6: The month wraps from 12 to 1 and carries into the year, and the year wraps from 99 to 00. The weekday advances with each new day and wraps from 7 to 1.
- R7: The `wrTime`, `wrDate` and `wrPresc` strobes take effect only while `inInit` is high. At any other time they are ignored.
- R8: While `inInit` is high, the calendar does not advance and the shadows hold their values. When init mode ends, both dividers restart from their reload values.
- R9: On every `rtcEn` cycle outside init mode, both shadow words are loaded together from the calendar value that stood before that edge. Without `rtcEn`, they hold.
- R10: `shadowValid` is 0 after reset and is forced to 0 during init mode. A `validClr` pulse clears it. Outside init mode, it rises on the second `rtcEn` edge after it went low.
- R11: Loading all-zero time and date is accepted and reads back as zero words.
- R12: `inInit` follows `initReq` with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rtcEn | input | 1 | One pulse per RTC clock edge |
| initReq | input | 1 | Requests init mode |
| wrTime | input | 1 | Load time from wrData (init mode only) |
| wrDate | input | 1 | Load date from wrData (init mode only) |
| wrPresc | input | 1 | Load divider reloads from wrData (init mode only) |
| validClr | input | 1 | Clears shadowValid |
| wrData | input | 24 | Load data for time, date or dividers |
| inInit | output | 1 | Init mode active |
| shadowValid | output | 1 | Shadow words coherent |
| shadowTime | output | 24 | Shadow time word |
| shadowDate | output | 24 | Shadow date word |

## Verification
On every cycle, the assertions check the local rules. These are: clearing the valid flag takes hold at once, the flag drops in init mode, the flag rises only on an RTC edge, the shadows hold between RTC edges and during init mode, and init mode tracks its request. Only the bench's scenarios can show the calendar arithmetic. That covers carries across digit boundaries, leap and non-leap February, 30-day months and the century wrap. The scenarios also show the divider ratio, both at reset values and at loaded values. A behavioural model compares every shadow field on every clock.

// File: rtl/rtcal_pkg.sv
package rtcal_pkg;

  localparam int WORD_W = 24;

  typedef struct packed {
    logic loadTime;
    logic loadDate;
    logic secTick;
    logic copyShadow;
  } calStrobe_t;

  // Increment a two-digit BCD value; the caller handles the wrap.
  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // Last day of a month in BCD, leap rule: year divisible by 4.
  function automatic logic [5:0] lastDayBcd(input logic [4:0] monBcd,
                                            input logic [7:0] yrBcd);
    logic [7:0] yrBin;
    yrBin = {1'b0, yrBcd[7:4], 3'b000} + {3'b000, yrBcd[7:4], 1'b0} + {4'd0, yrBcd[3:0]};
    case (monBcd)
      5'h02: return (yrBin[1:0] == 2'b00) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default: return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import rtcal_pkg::*;
#(
  parameter int ASYNC_W    = 7,
  parameter int SYNC_W     = 15,
  parameter int ASYNC_INIT = 127,
  parameter int SYNC_INIT  = 255
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rtcEn,
  input  logic               initReq,
  input  logic               wrTime,
  input  logic               wrDate,
  input  logic               wrPresc,
  input  logic               validClr,
  input  logic [ASYNC_W-1:0] asyncLoad,
  input  logic [SYNC_W-1:0]  syncLoad,
  output logic               inInit,
  output logic               shadowValid,
  output calStrobe_t         strb
);

  logic [ASYNC_W-1:0] asyncReload, asyncCnt;
  logic [SYNC_W-1:0]  syncReload, syncCnt;
  logic               asyncWrap, syncWrap, validPend;

  assign asyncWrap = (asyncCnt == '0);
  assign syncWrap  = (syncCnt == '0);

  always_comb begin
    strb.loadTime   = wrTime & inInit;
    strb.loadDate   = wrDate & inInit;
    strb.copyShadow = rtcEn & ~inInit;
    strb.secTick    = rtcEn & ~inInit & asyncWrap & syncWrap;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inInit <= 1'b0;
    else       inInit <= initReq;
  end

  // Divider reload registers, writable in init mode only.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asyncReload <= ASYNC_W'(ASYNC_INIT);
      syncReload  <= SYNC_W'(SYNC_INIT);
    end else if (inInit && wrPresc) begin
      asyncReload <= asyncLoad;
      syncReload  <= syncLoad;
    end
  end

  // Cascaded down-counters; held at reload while in init mode.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asyncCnt <= ASYNC_W'(ASYNC_INIT);
      syncCnt  <= SYNC_W'(SYNC_INIT);
    end else if (inInit) begin
      asyncCnt <= asyncReload;
      syncCnt  <= syncReload;
    end else if (rtcEn) begin
      if (asyncWrap) begin
        asyncCnt <= asyncReload;
        syncCnt  <= syncWrap ? syncReload : syncCnt - 1'b1;
      end else begin
        asyncCnt <= asyncCnt - 1'b1;
      end
    end
  end

  // Coherence flag: armed on the first RTC edge after going low, set on the second.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowValid <= 1'b0;
      validPend   <= 1'b0;
    end else if (inInit || validClr) begin
      shadowValid <= 1'b0;
      validPend   <= 1'b0;
    end else if (rtcEn && !shadowValid) begin
      shadowValid <= validPend;
      validPend   <= ~validPend;
    end
  end

endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
  import rtcal_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  calStrobe_t        strb,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] shadowTime,
  output logic [WORD_W-1:0] shadowDate
);

  logic [6:0] sec, min;
  logic [5:0] hour, day;
  logic [4:0] mon;
  logic [2:0] wday;
  logic [7:0] yr;

  logic [7:0] secInc, minInc, hourInc, dayInc, monInc, yrInc;
  logic       secWrap, minWrap, hourWrap, dayWrap, monWrap, yrWrap;
  logic       carryMin, carryHour, carryDay, carryMon, carryYr;
  logic       unusedPad;

  assign secInc  = bcdInc({1'b0, sec});
  assign minInc  = bcdInc({1'b0, min});
  assign hourInc = bcdInc({2'b0, hour});
  assign dayInc  = bcdInc({2'b0, day});
  assign monInc  = bcdInc({3'b0, mon});
  assign yrInc   = bcdInc(yr);

  assign secWrap  = (sec == 7'h59);
  assign minWrap  = (min == 7'h59);
  assign hourWrap = (hour == 6'h23);
  assign dayWrap  = (day == lastDayBcd(mon, yr));
  assign monWrap  = (mon == 5'h12);
  assign yrWrap   = (yr == 8'h99);

  assign carryMin  = strb.secTick & secWrap;
  assign carryHour = carryMin & minWrap;
  assign carryDay  = carryHour & hourWrap;
  assign carryMon  = carryDay & dayWrap;
  assign carryYr   = carryMon & monWrap;

  assign unusedPad = ^{wrData[7], secInc[7], minInc[7], hourInc[7:6],
                       dayInc[7:6], monInc[7:5]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sec <= '0; min <= '0; hour <= '0;
    end else if (strb.loadTime) begin
      sec  <= wrData[6:0];
      min  <= wrData[14:8];
      hour <= wrData[21:16];
    end else begin
      if (strb.secTick) sec  <= secWrap  ? '0 : secInc[6:0];
      if (carryMin)     min  <= minWrap  ? '0 : minInc[6:0];
      if (carryHour)    hour <= hourWrap ? '0 : hourInc[5:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      day <= '0; mon <= '0; wday <= '0; yr <= '0;
    end else if (strb.loadDate) begin
      day  <= wrData[5:0];
      mon  <= wrData[12:8];
      wday <= wrData[15:13];
      yr   <= wrData[23:16];
    end else begin
      if (carryDay) begin
        day  <= dayWrap ? 6'h01 : dayInc[5:0];
        wday <= (wday == 3'd7) ? 3'd1 : wday + 3'd1;
      end
      if (carryMon) mon <= monWrap ? 5'h01 : monInc[4:0];
      if (carryYr)  yr  <= yrWrap ? 8'h00 : yrInc;
    end
  end

  // Both shadows load on the same edge, from the pre-edge calendar.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowTime <= '0;
      shadowDate <= '0;
    end else if (strb.copyShadow) begin
      shadowTime <= {2'b00, hour, 1'b0, min, 1'b0, sec};
      shadowDate <= {yr, wday, mon, 2'b00, day};
    end
  end

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import rtcal_pkg::*;
#(
  parameter int ASYNC_W    = 7,
  parameter int SYNC_W     = 15,
  parameter int ASYNC_INIT = 127,
  parameter int SYNC_INIT  = 255
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rtcEn,
  input  logic              initReq,
  input  logic              wrTime,
  input  logic              wrDate,
  input  logic              wrPresc,
  input  logic              validClr,
  input  logic [WORD_W-1:0] wrData,
  output logic              inInit,
  output logic              shadowValid,
  output logic [WORD_W-1:0] shadowTime,
  output logic [WORD_W-1:0] shadowDate
);

  localparam int ASYNC_LSB = 16;

  calStrobe_t strb;

  cal_ctrl #(
    .ASYNC_W(ASYNC_W), .SYNC_W(SYNC_W),
    .ASYNC_INIT(ASYNC_INIT), .SYNC_INIT(SYNC_INIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .rtcEn(rtcEn), .initReq(initReq),
    .wrTime(wrTime), .wrDate(wrDate), .wrPresc(wrPresc), .validClr(validClr),
    .asyncLoad(wrData[ASYNC_LSB +: ASYNC_W]), .syncLoad(wrData[SYNC_W-1:0]),
    .inInit(inInit), .shadowValid(shadowValid), .strb(strb)
  );

  cal_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .shadowTime(shadowTime), .shadowDate(shadowDate)
  );

endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk (
  input logic        clk,
  input logic        rstN,
  input logic        rtcEn,
  input logic        initReq,
  input logic        validClr,
  input logic        inInit,
  input logic        shadowValid,
  input logic [23:0] shadowTime,
  input logic [23:0] shadowDate
);

  p_valid_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    validClr |=> !shadowValid);

  p_valid_init_r10: assert property (@(posedge clk) disable iff (!rstN)
    inInit |=> !shadowValid);

  p_valid_rise_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shadowValid) |-> $past(rtcEn));

  p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !rtcEn |=> ($stable(shadowTime) && $stable(shadowDate)));

  p_shadow_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    inInit |=> ($stable(shadowTime) && $stable(shadowDate)));

  p_init_enter_r12: assert property (@(posedge clk) disable iff (!rstN)
    initReq |=> inInit);

  p_init_leave_r12: assert property (@(posedge clk) disable iff (!rstN)
    !initReq |=> !inInit);

endmodule

bind bcd_calendar bcd_calendar_chk u_chk (
  .clk(clk), .rstN(rstN), .rtcEn(rtcEn), .initReq(initReq), .validClr(validClr),
  .inInit(inInit), .shadowValid(shadowValid),
  .shadowTime(shadowTime), .shadowDate(shadowDate)
);

// File: tb/bcd_calendar_tb.sv
module bcd_calendar_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rtcEn = 1'b0, initReq = 1'b0, wrTime = 1'b0, wrDate = 1'b0;
  logic        wrPresc = 1'b0, validClr = 1'b0;
  logic [23:0] wrData = '0;
  logic        inInit, shadowValid;
  logic [23:0] shadowTime, shadowDate;

  int checks = 0, failures = 0;
  bit live = 0, done = 0;

  always #5 clk = ~clk;

  bcd_calendar u_dut (
    .clk(clk), .rstN(rstN), .rtcEn(rtcEn), .initReq(initReq),
    .wrTime(wrTime), .wrDate(wrDate), .wrPresc(wrPresc), .validClr(validClr),
    .wrData(wrData), .inInit(inInit), .shadowValid(shadowValid),
    .shadowTime(shadowTime), .shadowDate(shadowDate)
  );

  function automatic int toBcd(input int v);
    return (v / 10) * 16 + (v % 10);
  endfunction
  function automatic int fromBcd(input int v);
    return (v / 16) * 10 + (v % 16);
  endfunction
  // R1 layout
  function automatic int packTime(input int h, input int m, input int s);
    return (toBcd(h) << 16) | (toBcd(m) << 8) | toBcd(s);
  endfunction
  // R2 layout
  function automatic int packDate(input int y, input int wd, input int mo, input int d);
    return (toBcd(y) << 16) | (wd << 13) | (toBcd(mo) << 8) | toBcd(d);
  endfunction
  function automatic int monthLen(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int mInit, aCnt, sCnt, aDiv, sDiv, mValid, mPend;
  int cSec, cMin, cHr, cDay, cMon, cYr, cWd;
  int shT, shD;

  task automatic modelReset();
    mInit = 0; aDiv = 127; sDiv = 255; aCnt = 127; sCnt = 255;
    mValid = 0; mPend = 0; shT = 0; shD = 0;
    cSec = 0; cMin = 0; cHr = 0; cDay = 0; cMon = 0; cYr = 0; cWd = 0;
  endtask

  task automatic advance();
    cSec++;
    if (cSec < 60) return;
    cSec = 0; cMin++;
    if (cMin < 60) return;
    cMin = 0; cHr++;
    if (cHr < 24) return;
    cHr = 0;
    cWd = (cWd == 7) ? 1 : cWd + 1;
    if (cDay == monthLen(cMon, cYr)) begin
      cDay = 1;
      if (cMon == 12) begin
        cMon = 1;
        cYr = (cYr == 99) ? 0 : cYr + 1;
      end else cMon++;
    end else cDay++;
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      int wasInit;
      bit tick;
      wasInit = mInit;
      mInit = initReq;
      if (wasInit != 0) begin
        aCnt = aDiv; sCnt = sDiv; mValid = 0; mPend = 0;
        if (wrPresc) begin aDiv = int'(wrData[22:16]); sDiv = int'(wrData[14:0]); end
        if (wrTime) begin
          cSec = fromBcd(int'(wrData[6:0])); cMin = fromBcd(int'(wrData[14:8]));
          cHr = fromBcd(int'(wrData[21:16]));
        end
        if (wrDate) begin
          cDay = fromBcd(int'(wrData[5:0])); cMon = fromBcd(int'(wrData[12:8]));
          cWd = int'(wrData[15:13]); cYr = fromBcd(int'(wrData[23:16]));
        end
      end else begin
        if (rtcEn) begin
          tick = 0;
          if (aCnt == 0) begin
            aCnt = aDiv;
            if (sCnt == 0) begin sCnt = sDiv; tick = 1; end
            else sCnt--;
          end else aCnt--;
          shT = packTime(cHr, cMin, cSec);
          shD = packDate(cYr, cWd, cMon, cDay);
          if (tick) advance();
        end
        if (validClr) begin mValid = 0; mPend = 0; end
        else if (rtcEn && mValid == 0) begin
          if (mPend != 0) begin mValid = 1; mPend = 0; end
          else mPend = 1;
        end
      end
    end
  end

  // Per-cycle comparison against the model (R4/R5/R6 fields, R9 timing, R10, R12)
  always @(negedge clk) begin
    if (live) begin
      chk(int'(shadowTime) == shT, "R4 shadow time", int'(shadowTime), shT);
      chk(int'(shadowDate) == shD, "R5/R6 shadow date", int'(shadowDate), shD);
      chk(int'(shadowValid) == mValid, "R10 valid flag", int'(shadowValid), mValid);
      chk(int'(inInit) == mInit, "R12 init flag", int'(inInit), mInit);
    end
  end

  task automatic runRtc(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) rtcEn = 1'b1;
      for (int g = 0; g < gap; g++) @(negedge clk) rtcEn = 1'b0;
    end
    @(negedge clk) rtcEn = 1'b0;
  endtask

  task automatic setCal(input int y, input int mo, input int d, input int wd,
                        input int h, input int m, input int s,
                        input int a, input int sy);
    @(negedge clk) initReq = 1'b1;
    @(negedge clk);
    chk(inInit == 1'b1, "R12 init entered", int'(inInit), 1);
    wrPresc = 1'b1; wrData = 24'((a << 16) | sy);
    @(negedge clk) wrPresc = 1'b0; wrTime = 1'b1; wrData = 24'(packTime(h, m, s));
    @(negedge clk) wrTime = 1'b0; wrDate = 1'b1; wrData = 24'(packDate(y, wd, mo, d));
    @(negedge clk) wrDate = 1'b0; initReq = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // Reset state: R1, R2, R10, R12
    chk(shadowTime == 24'h0, "R1 reset time", int'(shadowTime), 0);
    chk(shadowDate == 24'h0, "R2 reset date", int'(shadowDate), 0);
    chk(shadowValid == 1'b0, "R10 reset valid", int'(shadowValid), 0);
    chk(inInit == 1'b0, "R12 reset init", int'(inInit), 0);
    rstN = 1'b1;
    live = 1;

    // R3: default divider 128*256 edges per second
    runRtc(32769, 0);
    chk(shadowTime == 24'h000001, "R3 default ratio", int'(shadowTime), 1);

    // R5 leap February, ratio 2*2 (R3 loaded values, R9 gapped edges)
    setCal(24, 2, 28, 3, 23, 59, 58, 1, 1);
    runRtc(9, 2);
    chk(int'(shadowTime) == packTime(0, 0, 0), "R4 midnight", int'(shadowTime), packTime(0, 0, 0));
    chk(int'(shadowDate) == packDate(24, 4, 2, 29), "R5 leap day", int'(shadowDate), packDate(24, 4, 2, 29));
    chk(shadowValid == 1'b1, "R10 valid after run", int'(shadowValid), 1);

    // R5 non-leap February and R6 weekday 7 -> 1
    setCal(23, 2, 28, 7, 23, 59, 59, 1, 1);
    runRtc(5, 1);
    chk(int'(shadowDate) == packDate(23, 1, 3, 1), "R6 weekday wrap / R5 March", int'(shadowDate), packDate(23, 1, 3, 1));

    // R6 century wrap
    setCal(99, 12, 31, 5, 23, 59, 59, 1, 1);
    runRtc(5, 0);
    chk(int'(shadowDate) == packDate(0, 6, 1, 1), "R6 year wrap", int'(shadowDate), packDate(0, 6, 1, 1));

    // R4 hour tens digit
    setCal(22, 6, 15, 3, 19, 59, 58, 1, 1);
    runRtc(9, 1);
    chk(int'(shadowTime) == packTime(20, 0, 0), "R4 hour carry", int'(shadowTime), packTime(20, 0, 0));

    // R5 thirty-day month
    setCal(21, 4, 30, 2, 23, 59, 59, 1, 1);
    runRtc(5, 1);
    chk(int'(shadowDate) == packDate(21, 3, 5, 1), "R5 April end", int'(shadowDate), packDate(21, 3, 5, 1));

    // R7 writes outside init ignored: ratio and time unchanged
    @(negedge clk) wrTime = 1'b1; wrPresc = 1'b1; wrData = 24'h123456;
    @(negedge clk) wrTime = 1'b0; wrPresc = 1'b0; wrDate = 1'b1; wrData = 24'h000000;
    @(negedge clk) wrDate = 1'b0;
    runRtc(5, 1);
    chk(int'(shadowTime) == packTime(0, 0, 1), "R7 ignored time/presc", int'(shadowTime), packTime(0, 0, 1));
    chk(int'(shadowDate) == packDate(21, 3, 5, 1), "R7 ignored date", int'(shadowDate), packDate(21, 3, 5, 1));

    // R8 frozen in init
    @(negedge clk) initReq = 1'b1;
    runRtc(6, 1);
    chk(int'(shadowTime) == packTime(0, 0, 1), "R8 frozen shadow", int'(shadowTime), packTime(0, 0, 1));
    chk(shadowValid == 1'b0, "R10 low in init", int'(shadowValid), 0);
    @(negedge clk) initReq = 1'b0;
    @(negedge clk);

    // R10 valid flag sequence (R8 restart: first tick after 4 edges, checked by model)
    runRtc(1, 1);
    chk(shadowValid == 1'b0, "R10 one edge", int'(shadowValid), 0);
    runRtc(1, 1);
    chk(shadowValid == 1'b1, "R10 two edges", int'(shadowValid), 1);
    @(negedge clk) validClr = 1'b1;
    @(negedge clk) validClr = 1'b0;
    chk(shadowValid == 1'b0, "R10 cleared", int'(shadowValid), 0);
    runRtc(1, 0);
    chk(shadowValid == 1'b0, "R10 armed", int'(shadowValid), 0);
    runRtc(1, 0);
    chk(shadowValid == 1'b1, "R10 set again", int'(shadowValid), 1);

    // R11 all-zero load
    setCal(0, 0, 0, 0, 0, 0, 0, 1, 1);
    runRtc(1, 1);
    chk(shadowTime == 24'h0 && shadowDate == 24'h0, "R11 zero load", int'(shadowTime | shadowDate), 0);
    runRtc(4, 1);
    chk(shadowTime == 24'h000001, "R11 zero advances", int'(shadowTime), 1);

    live = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule